// File: doc/BRIEF.md
# LDPC Code Rate Index Selector

This block picks the code rate index and the resulting codeword length for one code block ahead of 5G NR LDPC decoding. A caller presents the base graph, the lifting size Zc, the number of filler (null) bits, the starting position k0, the rate-matched length E, the circular buffer size Ncb, and the HARQ state. The caller then pulses `start`. The caller supplies Zc, k0 and Ncb directly; this block derives none of them.

The block first works out how far into the circular buffer the received bits reach. If k0 lies ahead of the filler region, the filler bits are added to the span. The span is then capped at Ncb. When HARQ combining is active, the span is raised to at least the length already stored from earlier transmissions. The block then tries rate candidates one per clock, starting with the shortest codeword. It stops at the first candidate whose codeword covers the span. If no candidate fits, it reports an error. The result is returned with a single-cycle `done` pulse and stays on the outputs until the next result.

Top module: `ldpc_code_rate_sel`

## Requirements
- R1: With `bg_sel`=0 (graph 1), K−2·Zc is 20·Zc. With `bg_sel`=1 (graph 2), K−2·Zc is 8·Zc. When k0 + null_cnt < K−2·Zc, the span is k0 + E + null_cnt.
- R2: When k0 + null_cnt ≥ K−2·Zc, the span is k0 + E, and no filler bits are added.
- R3: With `harq_en`=0, the covered length LCB is min(Ncb, span).
- R4: With `harq_en`=1, LCB is max(min(Ncb, span), old_len).
- R5: The candidates are tried in a fixed order, and `rate_idx` is the first one with LCB ≤ cols·Zc. For graph 1 the order is indices 7,6,5,4,3,2,1 with column counts 25,27,30,33,44,55,66. For graph 2 the order is indices 4,3,2,1,0 with column counts 15,20,25,30,50.
- R6: On success, `cw_len` equals the column count of the chosen index times Zc, and `err` is 0.
- R7: If no candidate covers LCB, `done` comes with `err`=1, `rate_idx`=0 and `cw_len`=0.
- R8: `done` is high for exactly one cycle. It rises 2 + (n−1) clock edges after the edge that samples `start`, where n is the number of candidates examined.
- R9: While a computation is in progress, `start` and all input changes are ignored. `rate_idx`, `cw_len` and `err` change only in a `done` cycle.
- R10: After synchronous active-low reset, `done`, `err`, `rate_idx` and `cw_len` are all 0.
- R11: Zc up to 384, E up to 2^21−1 and k0 up to 2^15−1 give exact results, with no wraparound in the span or the codeword length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a selection; sampled only when idle |
| bg_sel | input | 1 | 0 = base graph 1, 1 = base graph 2 |
| zc | input | 9 | Lifting size Zc |
| null_cnt | input | 10 | Number of filler bits (K−K') |
| k0 | input | 15 | Circular buffer start position |
| e_len | input | 21 | Rate-matched length E |
| ncb | input | 15 | Circular buffer size Ncb |
| old_len | input | 15 | Previously combined length |
| harq_en | input | 1 | 1 = include the previous combined length |
| done | output | 1 | One-cycle completion strobe |
| err | output | 1 | No rate candidate fits |
| rate_idx | output | 3 | Selected code rate index |
| cw_len | output | 16 | Selected codeword length |

## Verification
The bench builds the block with its default widths: a 9-bit Zc, a 21-bit E, and 15-bit k0, Ncb and previous length. These widths let the largest lifting size and an E near 2^21 sit next to the smallest lifting sizes, where the longest scans and the error exits of both graphs occur. Directed vectors straddle the k0-versus-filler threshold by one position. They also hit exact equality between LCB and a codeword length, and let the previous HARQ length win over the Ncb cap. A randomised sweep covers mixed graph and HARQ combinations, and each one is compared every clock against a behavioural latency model.

// File: rtl/ldpc_crsel_pkg.sv
// Package: shared types and table functions for the code rate selector.
// Assumes index 0 of graph 1 and indices 5..7 of graph 2 are never visited.
package ldpc_crsel_pkg;

    localparam int NB_W  = 7;
    localparam int IDX_W = 3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SPAN = 2'd1,
        ST_SCAN = 2'd2
    } crsel_state_e;

    // Column count for a base graph and rate index.
    function automatic logic [NB_W-1:0] nb_cols(input logic bg2, input logic [IDX_W-1:0] idx);
        logic [NB_W-1:0] v;
        if (!bg2) begin
            case (idx)
                3'd1:    v = 7'd66;
                3'd2:    v = 7'd55;
                3'd3:    v = 7'd44;
                3'd4:    v = 7'd33;
                3'd5:    v = 7'd30;
                3'd6:    v = 7'd27;
                3'd7:    v = 7'd25;
                default: v = 7'd0;
            endcase
        end else begin
            case (idx)
                3'd0:    v = 7'd50;
                3'd1:    v = 7'd30;
                3'd2:    v = 7'd25;
                3'd3:    v = 7'd20;
                3'd4:    v = 7'd15;
                default: v = 7'd0;
            endcase
        end
        return v;
    endfunction

    // First candidate to try for a graph.
    function automatic logic [IDX_W-1:0] first_idx(input logic bg2);
        return bg2 ? 3'd4 : 3'd7;
    endfunction

    // Last candidate to try for a graph.
    function automatic logic [IDX_W-1:0] last_idx(input logic bg2);
        return bg2 ? 3'd0 : 3'd1;
    endfunction

endpackage

// File: rtl/ldpc_crsel_inreg.sv
// Module: holds the request fields for the length of one selection.
// Assumes load is only raised by the controller while it is idle.
module ldpc_crsel_inreg #(
    parameter int ZC_W   = 9,
    parameter int NULL_W = 10,
    parameter int K0_W   = 15,
    parameter int E_W    = 21,
    parameter int NCB_W  = 15,
    parameter int OLD_W  = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              bg_sel,
    input  logic [ZC_W-1:0]   zc,
    input  logic [NULL_W-1:0] null_cnt,
    input  logic [K0_W-1:0]   k0,
    input  logic [E_W-1:0]    e_len,
    input  logic [NCB_W-1:0]  ncb,
    input  logic [OLD_W-1:0]  old_len,
    input  logic              harq_en,
    output logic              bg2_q,
    output logic [ZC_W-1:0]   zc_q,
    output logic [NULL_W-1:0] null_q,
    output logic [K0_W-1:0]   k0_q,
    output logic [E_W-1:0]    e_q,
    output logic [NCB_W-1:0]  ncb_q,
    output logic [OLD_W-1:0]  old_q,
    output logic              harq_q
);

    // Capture the request on load; otherwise keep it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bg2_q  <= 1'b0;
            zc_q   <= '0;
            null_q <= '0;
            k0_q   <= '0;
            e_q    <= '0;
            ncb_q  <= '0;
            old_q  <= '0;
            harq_q <= 1'b0;
        end else if (load) begin
            bg2_q  <= bg_sel;
            zc_q   <= zc;
            null_q <= null_cnt;
            k0_q   <= k0;
            e_q    <= e_len;
            ncb_q  <= ncb;
            old_q  <= old_len;
            harq_q <= harq_en;
        end
    end

endmodule

// File: rtl/ldpc_crsel_span.sv
// Module: combinational covered-length calculation (span, Ncb cap, HARQ floor).
// Assumes SPAN_W is wide enough for k0 + E + null_cnt and for 20*Zc.
module ldpc_crsel_span #(
    parameter int ZC_W   = 9,
    parameter int NULL_W = 10,
    parameter int K0_W   = 15,
    parameter int E_W    = 21,
    parameter int NCB_W  = 15,
    parameter int OLD_W  = 15,
    parameter int SPAN_W = 23
) (
    input  logic              bg2,
    input  logic [ZC_W-1:0]   zc,
    input  logic [NULL_W-1:0] null_cnt,
    input  logic [K0_W-1:0]   k0,
    input  logic [E_W-1:0]    e_len,
    input  logic [NCB_W-1:0]  ncb,
    input  logic [OLD_W-1:0]  old_len,
    input  logic              harq_en,
    output logic [SPAN_W-1:0] lcb
);

    logic [SPAN_W-1:0] zc_x, null_x, k0_x, e_x, ncb_x, old_x;
    logic [SPAN_W-1:0] sys_end, span, capped;
    logic              ahead_of_null;

    // Widen every operand to the common arithmetic width.
    always_comb begin
        zc_x   = SPAN_W'(zc);
        null_x = SPAN_W'(null_cnt);
        k0_x   = SPAN_W'(k0);
        e_x    = SPAN_W'(e_len);
        ncb_x  = SPAN_W'(ncb);
        old_x  = SPAN_W'(old_len);
    end

    // Start of the filler region: K - 2*Zc (20*Zc or 8*Zc), shift-add only.
    always_comb begin
        if (bg2) sys_end = zc_x << 3;
        else     sys_end = (zc_x << 4) + (zc_x << 2);
    end

    // Decide whether k0 sits ahead of the filler bits and form the span.
    always_comb begin
        ahead_of_null = (k0_x + null_x) < sys_end;
        span          = k0_x + e_x + (ahead_of_null ? null_x : '0);
    end

    // Cap at Ncb, then raise to the stored HARQ length when enabled.
    always_comb begin
        capped = (span < ncb_x) ? span : ncb_x;
        lcb    = (harq_en && (old_x > capped)) ? old_x : capped;
    end

endmodule

// File: rtl/ldpc_crsel_cand.sv
// Module: codeword length of one rate candidate (column count times Zc).
// Assumes CW_W >= NB_W + ZC_W so the product never wraps.
module ldpc_crsel_cand
    import ldpc_crsel_pkg::*;
#(
    parameter int ZC_W = 9,
    parameter int CW_W = 16
) (
    input  logic             bg2,
    input  logic [IDX_W-1:0] idx,
    input  logic [ZC_W-1:0]  zc,
    output logic [CW_W-1:0]  cand_len
);

    logic [NB_W-1:0] cols;

    // Table lookup followed by the multiply.
    always_comb begin
        cols     = nb_cols(bg2, idx);
        cand_len = CW_W'(cols) * CW_W'(zc);
    end

endmodule

// File: rtl/ldpc_crsel_ctrl.sv
// Module: sequencer that registers LCB and then tests one candidate per clock.
// Assumes lcb and cand_len are combinational from captured state.
module ldpc_crsel_ctrl
    import ldpc_crsel_pkg::*;
#(
    parameter int SPAN_W = 23,
    parameter int CW_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              bg2_q,
    input  logic [SPAN_W-1:0] lcb,
    input  logic [CW_W-1:0]   cand_len,
    output logic              load,
    output crsel_state_e      state,
    output logic [IDX_W-1:0]  idx,
    output logic              done,
    output logic              err,
    output logic [IDX_W-1:0]  rate_idx,
    output logic [CW_W-1:0]   cw_len
);

    localparam int CMP_W = SPAN_W + CW_W;

    logic [SPAN_W-1:0] lcb_q;
    logic              fits;
    logic              at_last;

    // Accept a request only in idle.
    always_comb load = (state == ST_IDLE) && start;

    // Candidate test and end-of-list detection.
    always_comb begin
        fits    = CMP_W'(lcb_q) <= CMP_W'(cand_len);
        at_last = (idx == last_idx(bg2_q));
    end

    // State sequence, scan index and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            idx      <= '0;
            lcb_q    <= '0;
            done     <= 1'b0;
            err      <= 1'b0;
            rate_idx <= '0;
            cw_len   <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) state <= ST_SPAN;
                end
                ST_SPAN: begin
                    lcb_q <= lcb;
                    idx   <= first_idx(bg2_q);
                    state <= ST_SCAN;
                end
                ST_SCAN: begin
                    if (fits) begin
                        done     <= 1'b1;
                        err      <= 1'b0;
                        rate_idx <= idx;
                        cw_len   <= cand_len;
                        state    <= ST_IDLE;
                    end else if (at_last) begin
                        done     <= 1'b1;
                        err      <= 1'b1;
                        rate_idx <= '0;
                        cw_len   <= '0;
                        state    <= ST_IDLE;
                    end else begin
                        idx <= idx - 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/ldpc_code_rate_sel.sv
// Module: top of the code rate index selector (start/done handshake).
// Assumes callers hold no expectation on inputs after the start edge.
module ldpc_code_rate_sel
    import ldpc_crsel_pkg::*;
#(
    parameter int ZC_W   = 9,
    parameter int NULL_W = 10,
    parameter int K0_W   = 15,
    parameter int E_W    = 21,
    parameter int NCB_W  = 15,
    parameter int OLD_W  = 15,
    localparam int WIDEST = (E_W > K0_W) ? E_W : K0_W,
    localparam int SPAN_W = ((WIDEST > ZC_W + 5) ? WIDEST : ZC_W + 5) + 2,
    localparam int CW_W   = ZC_W + NB_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              bg_sel,
    input  logic [ZC_W-1:0]   zc,
    input  logic [NULL_W-1:0] null_cnt,
    input  logic [K0_W-1:0]   k0,
    input  logic [E_W-1:0]    e_len,
    input  logic [NCB_W-1:0]  ncb,
    input  logic [OLD_W-1:0]  old_len,
    input  logic              harq_en,
    output logic              done,
    output logic              err,
    output logic [IDX_W-1:0]  rate_idx,
    output logic [CW_W-1:0]   cw_len
);

    logic              load;
    crsel_state_e      state;
    logic [IDX_W-1:0]  idx;
    logic              bg2_q, harq_q;
    logic [ZC_W-1:0]   zc_q;
    logic [NULL_W-1:0] null_q;
    logic [K0_W-1:0]   k0_q;
    logic [E_W-1:0]    e_q;
    logic [NCB_W-1:0]  ncb_q;
    logic [OLD_W-1:0]  old_q;
    logic [SPAN_W-1:0] lcb;
    logic [CW_W-1:0]   cand_len;

    ldpc_crsel_inreg #(
        .ZC_W(ZC_W), .NULL_W(NULL_W), .K0_W(K0_W),
        .E_W(E_W), .NCB_W(NCB_W), .OLD_W(OLD_W)
    ) u_inreg (
        .clk(clk), .rst_n(rst_n), .load(load),
        .bg_sel(bg_sel), .zc(zc), .null_cnt(null_cnt), .k0(k0),
        .e_len(e_len), .ncb(ncb), .old_len(old_len), .harq_en(harq_en),
        .bg2_q(bg2_q), .zc_q(zc_q), .null_q(null_q), .k0_q(k0_q),
        .e_q(e_q), .ncb_q(ncb_q), .old_q(old_q), .harq_q(harq_q)
    );

    ldpc_crsel_span #(
        .ZC_W(ZC_W), .NULL_W(NULL_W), .K0_W(K0_W),
        .E_W(E_W), .NCB_W(NCB_W), .OLD_W(OLD_W), .SPAN_W(SPAN_W)
    ) u_span (
        .bg2(bg2_q), .zc(zc_q), .null_cnt(null_q), .k0(k0_q),
        .e_len(e_q), .ncb(ncb_q), .old_len(old_q), .harq_en(harq_q),
        .lcb(lcb)
    );

    ldpc_crsel_cand #(.ZC_W(ZC_W), .CW_W(CW_W)) u_cand (
        .bg2(bg2_q), .idx(idx), .zc(zc_q), .cand_len(cand_len)
    );

    ldpc_crsel_ctrl #(.SPAN_W(SPAN_W), .CW_W(CW_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .bg2_q(bg2_q),
        .lcb(lcb), .cand_len(cand_len), .load(load), .state(state),
        .idx(idx), .done(done), .err(err), .rate_idx(rate_idx),
        .cw_len(cw_len)
    );

endmodule

// File: rtl/ldpc_crsel_chk.sv
// Module: property checker bound into the selector top.
// Assumes synchronous active-low reset; every property is off during reset.
module ldpc_crsel_chk
    import ldpc_crsel_pkg::*;
#(
    parameter int CW_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             done,
    input  logic             err,
    input  logic [IDX_W-1:0] rate_idx,
    input  logic [CW_W-1:0]  cw_len,
    input  logic             bg2_q,
    input  crsel_state_e     state
);

    // R8: the completion strobe never lasts two cycles.
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: an error result carries zero index and zero length.
    a_r7_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> (rate_idx == '0 && cw_len == '0));

    // R6: a successful result has a non-zero codeword length.
    a_r6_len_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> (cw_len != '0));

    // R5: graph 2 results stay within indices 0..4.
    a_r5_bg2_range: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err && bg2_q) |-> (rate_idx <= 3'd4));

    // R5: graph 1 results never use index 0.
    a_r5_bg1_range: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err && !bg2_q) |-> (rate_idx != 3'd0));

    // R9: results only move in a done cycle.
    a_r9_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(rate_idx) && $stable(cw_len) && $stable(err)));

    // R9: the captured request does not change while work is in progress.
    a_r9_capture_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SCAN) |=> $stable(bg2_q));

endmodule

bind ldpc_code_rate_sel ldpc_crsel_chk #(.CW_W(CW_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .done(done), .err(err),
    .rate_idx(rate_idx), .cw_len(cw_len), .bg2_q(bg2_q), .state(state)
);

// File: tb/sim_ldpc_code_rate_sel.sv
// Bench: behavioural latency/result model compared every clock.
module sim_ldpc_code_rate_sel;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        bg_sel = 1'b0;
    logic [8:0]  zc = '0;
    logic [9:0]  null_cnt = '0;
    logic [14:0] k0 = '0;
    logic [20:0] e_len = '0;
    logic [14:0] ncb = '0;
    logic [14:0] old_len = '0;
    logic        harq_en = 1'b0;
    logic        done, err;
    logic [2:0]  rate_idx;
    logic [15:0] cw_len;

    always #2.5 clk = ~clk;

    ldpc_code_rate_sel u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .bg_sel(bg_sel), .zc(zc),
        .null_cnt(null_cnt), .k0(k0), .e_len(e_len), .ncb(ncb),
        .old_len(old_len), .harq_en(harq_en), .done(done), .err(err),
        .rate_idx(rate_idx), .cw_len(cw_len)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    string cur_tag = "R10";
    string vec_tag = "R5";

    // Model state
    bit      m_busy = 0;
    int      m_cnt = 0;
    bit      m_done = 0;
    int      p_idx = 0, p_len = 0;
    bit      p_err = 0;
    int      h_idx = 0, h_len = 0;
    bit      h_err = 0;
    int      seen_done = 0;

    // Reference: returns index, length, error and number of candidates examined.
    task automatic reference(input bit bg2, input longint z, input longint nl,
                             input longint kk, input longint e, input longint nc,
                             input longint old, input bit harq,
                             output int ridx, output int rlen, output bit rerr,
                             output int evals);
        int nb1[8] = '{0, 66, 55, 44, 33, 30, 27, 25};
        int nb2[8] = '{50, 30, 25, 20, 15, 0, 0, 0};
        longint sysb, span, l;
        int first, last;
        sysb = bg2 ? 8 * z : 20 * z;
        span = (kk + nl < sysb) ? kk + e + nl : kk + e;
        l = (span < nc) ? span : nc;
        if (harq && old > l) l = old;
        first = bg2 ? 4 : 7;
        last  = bg2 ? 0 : 1;
        ridx = 0; rlen = 0; rerr = 1; evals = 0;
        for (int i = first; i >= last; i--) begin
            longint c;
            c = (bg2 ? nb2[i] : nb1[i]) * z;
            evals++;
            if (l <= c) begin
                ridx = i; rlen = int'(c); rerr = 0;
                break;
            end
        end
    endtask

    // Model update, one step per clock edge.
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_busy = 0; m_cnt = 0; m_done = 0;
            h_idx = 0; h_len = 0; h_err = 0;
        end else begin
            bit was_busy;
            was_busy = m_busy;
            m_done = 0;
            if (m_busy) begin
                if (m_cnt == 0) begin
                    m_done = 1; m_busy = 0;
                    h_idx = p_idx; h_len = p_len; h_err = p_err;
                    seen_done++;
                end else m_cnt--;
            end
            if (!was_busy && start) begin
                int ev;
                reference(bg_sel, zc, null_cnt, k0, e_len, ncb, old_len, harq_en,
                          p_idx, p_len, p_err, ev);
                m_busy = 1; m_cnt = ev;
                cur_tag = vec_tag;
            end
        end
    end

    // Compare the outputs with the model mid-cycle.
    always @(negedge clk) begin
        n_checks++;
        if (done !== m_done) begin
            n_fail++;
            $display("FAIL %s (R8 timing): done=%0b expected %0b at cycle %0d",
                     cur_tag, done, m_done, cycles);
        end
        n_checks++;
        if (rate_idx !== 3'(h_idx) || cw_len !== 16'(h_len) || err !== h_err) begin
            n_fail++;
            $display("FAIL %s: idx=%0d len=%0d err=%0b expected idx=%0d len=%0d err=%0b",
                     rst_n ? cur_tag : "R10", rate_idx, cw_len, err, h_idx, h_len, h_err);
        end
    end

    // Issue one request and wait for its completion.
    task automatic run_vec(input string tag, input bit bg2, input int z, input int nl,
                           input int kk, input int e, input int nc, input int old,
                           input bit harq);
        int target;
        @(negedge clk);
        vec_tag = tag;
        bg_sel = bg2; zc = 9'(z); null_cnt = 10'(nl); k0 = 15'(kk);
        e_len = 21'(e); ncb = 15'(nc); old_len = 15'(old); harq_en = harq;
        start = 1'b1;
        target = seen_done + 1;
        @(negedge clk);
        start = 1'b0;
        while (seen_done < target) @(negedge clk);
        @(negedge clk);
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R8 watchdog: run did not finish, got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (6) @(negedge clk);
        rst_n = 1'b1;
        // R6/R11: largest Zc, first candidate fits (25*384).
        run_vec("R6", 0, 384, 0, 0, 8448, 25344, 0, 0);
        // R11: E near the top of its range, span clipped by Ncb; graph 1, index 1.
        run_vec("R11", 0, 2, 0, 0, 2097151, 132, 0, 0);
        // R1: k0 one below the filler start -> fillers added -> index 6 (432).
        run_vec("R1", 0, 16, 40, 279, 100, 1056, 0, 0);
        // R2: k0 at the filler start -> no fillers -> index 7 (400).
        run_vec("R2", 0, 16, 40, 280, 100, 1056, 0, 0);
        // R1: graph 2, filler threshold 8*Zc.
        run_vec("R1", 1, 20, 10, 149, 200, 1000, 0, 0);
        run_vec("R2", 1, 20, 10, 150, 200, 1000, 0, 0);
        // R3: HARQ off ignores a large old length.
        run_vec("R3", 1, 32, 0, 0, 300, 1600, 1500, 0);
        // R4: HARQ on raises LCB to the old length.
        run_vec("R4", 1, 32, 0, 0, 300, 1600, 1500, 1);
        // R5: exact equality with 33*Zc selects index 4.
        run_vec("R5", 0, 10, 0, 0, 330, 660, 0, 0);
        // R5: graph 2 lowest index 0 (50*Zc).
        run_vec("R5", 1, 10, 0, 0, 500, 500, 0, 0);
        // R7: no candidate fits in graph 1 and in graph 2.
        run_vec("R7", 0, 10, 0, 0, 5000, 661, 0, 0);
        run_vec("R7", 1, 10, 0, 0, 5000, 501, 0, 0);
        // R9: a second start during a computation is ignored.
        @(negedge clk);
        vec_tag = "R9";
        bg_sel = 0; zc = 9'd16; null_cnt = '0; k0 = '0; e_len = 21'd1000;
        ncb = 15'd1056; old_len = '0; harq_en = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        bg_sel = 1; zc = 9'd2; e_len = 21'd1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (12) @(negedge clk);
        // R5: randomised sweep across graphs and HARQ.
        for (int v = 0; v < 300; v++) begin
            run_vec("R5", 1'($urandom_range(0, 1)), $urandom_range(2, 384),
                    $urandom_range(0, 1023), $urandom_range(0, 32767),
                    $urandom_range(0, 30000), $urandom_range(0, 32767),
                    $urandom_range(0, 32767), 1'($urandom_range(0, 1)));
        end
        // R10: reset clears everything.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule